// File: doc/BRIEF.md
# Frame-to-Video-Stream Converter with Programmable Blanking

This block turns a fixed-size frame of pixels, pulled one sample per cycle from a valid/ready pixel source, into a video pixel stream on an AXI4-Stream master port. The port carries data, valid, ready, a start-of-frame flag on TUSER and an end-of-line flag on TLAST. The active width and height are fixed when the block is built. Between lines and after each frame it inserts blanking periods during which TVALID stays low and no pixel is taken from the source.

The horizontal blank is a count of cycles. The vertical blank is a count of whole line periods, and each line period lasts the active width plus the horizontal blank. Both counts come from plain configuration inputs that stand in for control registers. They are copied into working registers only when one frame hands over to the next, so a change made during a frame first applies to the following frame. After reset the working registers hold build-time defaults of 280 cycles and 45 lines.

The scan is driven by a three-state controller:
- `ST_LINE`: fetches active pixels.
- `ST_HGAP`: counts the horizontal blank.
- `ST_VGAP`: counts the vertical blank lines.

The controller makes these transitions:
- `ST_LINE`→`ST_HGAP`: on the fetch of a line's last pixel when the horizontal blank is nonzero.
- `ST_LINE`→`ST_VGAP`: on the fetch of a frame's last pixel when the horizontal blank is zero and the vertical blank is nonzero.
- `ST_LINE`→`ST_LINE`: on the fetch of a line's last pixel when no blank follows it.
- `ST_HGAP`→`ST_VGAP`: at the end of the horizontal blank after a frame's last line when the vertical blank is nonzero.
- `ST_HGAP`→`ST_LINE`: at the end of the horizontal blank in every other case.
- `ST_VGAP`→`ST_LINE`: at the end of the last vertical blank line.

The gap counters advance only on cycles when the output register is empty. In the last cycle of a blank the controller fetches the next line's first pixel early, so the output shows no extra idle cycle.

Top module: `video_frame_streamer`

## Requirements
- R1: Every pixel accepted from the source appears once on `m_tdata`, in the order it was accepted. A frame is ACT_W pixels per line and ACT_H lines, scanned left to right and then top to bottom.
- R2: `m_tuser` is 1 on the first pixel of every frame (line 0, column 0) and 0 on every other transfer.
- R3: `m_tlast` is 1 on column ACT_W-1 of every line and 0 on every other transfer.
- R4: Assume the source always has data and the sink is always ready. Between the last transfer of a line (other than a frame's last line) and the next transfer, `m_tvalid` is low for exactly HG cycles, where HG is the frame's working horizontal blank.
- R5: Under the same conditions, after a frame's last line `m_tvalid` is low for exactly HG + VG×(ACT_W+HG) cycles, where VG is the frame's working vertical blank in lines.
- R6: `cfg_hgap` and `cfg_vgap` are copied only when one frame ends and the next begins. A change made during a frame does not alter that frame's blanks and applies from the next frame.
- R7: While `m_tvalid` is 1 and `m_tready` is 0, the next cycle keeps `m_tvalid` high with `m_tdata`, `m_tuser` and `m_tlast` unchanged, and `src_ready` is 0.
- R8: During a blank, the only pixel taken from the source is the next line's first pixel, fetched in the blank's final cycle. When the blank is zero, no pixel is taken between the two transfers.
- R9: A horizontal blank of 0 sends lines back to back. A vertical blank of 0 adds no blank lines after the frame.
- R10: While in reset and right after it, `m_tvalid` is 0 and `src_ready` is 1. The first frame after reset uses the default blanks (280 cycles, 45 lines).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hgap | input | HGAP_W | Horizontal blank length in cycles, from a control register |
| cfg_vgap | input | VGAP_W | Vertical blank length in line periods, from a control register |
| src_data | input | DATA_W | Pixel from the frame source |
| src_valid | input | 1 | Source pixel is available |
| src_ready | output | 1 | Block takes the source pixel this cycle |
| m_tdata | output | DATA_W | Stream pixel data |
| m_tvalid | output | 1 | Stream pixel valid |
| m_tready | input | 1 | Downstream accepts the pixel |
| m_tuser | output | 1 | Start-of-frame flag |
| m_tlast | output | 1 | End-of-line flag |

## Verification
The bench builds the block with an 8×3 frame, 16-bit pixels and the default blanks of 280 and 45. The first frame therefore runs the full default timing, including a trailing gap of 13,240 cycles, within a short run. The small frame lets the bench send six frames, covering reset defaults, blank values written during a frame, zero horizontal and vertical blanks together, a one-line vertical blank, and two frames with random source and sink stalls. The three-line height means every frame has both inner-line gaps and a frame-end gap.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

    typedef enum logic [1:0] {
        ST_LINE = 2'd0,
        ST_HGAP = 2'd1,
        ST_VGAP = 2'd2
    } raster_state_e;

    typedef struct packed {
        logic sof;
        logic eol;
    } pix_mark_t;

endpackage

// File: rtl/vfs_gap_regs.sv
module vfs_gap_regs #(
    parameter int HGAP_W   = 12,
    parameter int VGAP_W   = 8,
    parameter int HGAP_DEF = 280,
    parameter int VGAP_DEF = 45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [HGAP_W-1:0] cfg_hgap,
    input  logic [VGAP_W-1:0] cfg_vgap,
    output logic [HGAP_W-1:0] hgap,
    output logic [VGAP_W-1:0] vgap
);

    localparam logic [HGAP_W-1:0] HG_RST = HGAP_W'(HGAP_DEF);
    localparam logic [VGAP_W-1:0] VG_RST = VGAP_W'(VGAP_DEF);

    // working copies change only at a frame hand-over
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hgap <= HG_RST;
            vgap <= VG_RST;
        end else if (frame_done) begin
            hgap <= cfg_hgap;
            vgap <= cfg_vgap;
        end
    end

endmodule

// File: rtl/vfs_raster_fsm.sv
module vfs_raster_fsm
    import vfs_pkg::*;
#(
    parameter int ACT_W  = 1920,
    parameter int ACT_H  = 1080,
    parameter int HGAP_W = 12,
    parameter int VGAP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_busy,
    input  logic              take,
    input  logic [HGAP_W-1:0] hgap,
    input  logic [VGAP_W-1:0] vgap,
    output logic              fetch_ok,
    output pix_mark_t         fetch_mark,
    output logic              frame_done
);

    localparam int COL_W = (ACT_W > 1) ? $clog2(ACT_W) : 1;
    localparam int ROW_W = (ACT_H > 1) ? $clog2(ACT_H) : 1;
    localparam int LEN_W = ((HGAP_W > COL_W) ? HGAP_W : COL_W) + 1;
    localparam int VC_W  = VGAP_W + 1;
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(ACT_W - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ACT_H - 1);

    raster_state_e st_q, st_d;

    logic [COL_W-1:0]  col_q;
    logic [ROW_W-1:0]  row_q;
    logic [LEN_W-1:0]  gcnt_q;
    logic [VGAP_W-1:0] vcnt_q;

    logic             col_last, row_last, frame_gap;
    logic             hgap_zero, vgap_zero;
    logic [LEN_W-1:0] line_len, gcnt_inc;
    logic [VC_W-1:0]  vcnt_inc;
    logic             hgap_end, vline_end, vgap_end;

    always_comb begin
        col_last  = (col_q == COL_LAST);
        row_last  = (row_q == ROW_LAST);
        frame_gap = (row_q == '0);
        hgap_zero = (hgap == '0);
        vgap_zero = (vgap == '0);
        line_len  = LEN_W'(ACT_W) + LEN_W'(hgap);
        gcnt_inc  = gcnt_q + LEN_W'(1);
        vcnt_inc  = {1'b0, vcnt_q} + VC_W'(1);
        hgap_end  = (st_q == ST_HGAP) && !out_busy && (gcnt_inc == LEN_W'(hgap));
        vline_end = (st_q == ST_VGAP) && !out_busy && (gcnt_inc == line_len);
        vgap_end  = vline_end && (vcnt_inc == {1'b0, vgap});
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_LINE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LINE: begin
                if (take && col_last) begin
                    if (!hgap_zero)                st_d = ST_HGAP;
                    else if (row_last && !vgap_zero) st_d = ST_VGAP;
                end
            end
            ST_HGAP: begin
                if (hgap_end) st_d = (frame_gap && !vgap_zero) ? ST_VGAP : ST_LINE;
            end
            ST_VGAP: begin
                if (vgap_end) st_d = ST_LINE;
            end
            default: st_d = ST_LINE;
        endcase
    end

    // outputs
    always_comb begin
        fetch_ok   = 1'b0;
        frame_done = 1'b0;
        unique case (st_q)
            ST_LINE: begin
                fetch_ok   = 1'b1;
                frame_done = take && col_last && row_last && hgap_zero && vgap_zero;
            end
            ST_HGAP: begin
                fetch_ok   = hgap_end && !(frame_gap && !vgap_zero);
                frame_done = hgap_end && frame_gap && vgap_zero;
            end
            ST_VGAP: begin
                fetch_ok   = vgap_end;
                frame_done = vgap_end;
            end
            default: begin
                fetch_ok   = 1'b0;
                frame_done = 1'b0;
            end
        endcase
        fetch_mark.sof = (col_q == '0) && (row_q == '0);
        fetch_mark.eol = col_last;
    end

    // raster position of the next pixel to fetch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (take) begin
            col_q <= col_last ? '0 : col_q + COL_W'(1);
            if (col_last) row_q <= row_last ? '0 : row_q + ROW_W'(1);
        end
    end

    // blank counters, advanced only while the output stage is empty
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcnt_q <= '0;
            vcnt_q <= '0;
        end else begin
            if (st_d != st_q)
                gcnt_q <= '0;
            else if ((st_q != ST_LINE) && !out_busy)
                gcnt_q <= vline_end ? '0 : gcnt_inc;

            if (st_q != ST_VGAP)
                vcnt_q <= '0;
            else if (vline_end)
                vcnt_q <= vcnt_inc[VGAP_W-1:0];
        end
    end

endmodule

// File: rtl/vfs_out_reg.sv
module vfs_out_reg
    import vfs_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] in_data,
    input  pix_mark_t         in_mark,
    input  logic              m_tready,
    output logic              slot_free,
    output logic              busy,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tuser,
    output logic              m_tlast
);

    logic        vld_q;
    logic [DATA_W-1:0] dat_q;
    pix_mark_t   mrk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
            mrk_q <= '0;
        end else if (slot_free) begin
            vld_q <= take;
            if (take) begin
                dat_q <= in_data;
                mrk_q <= in_mark;
            end
        end
    end

    always_comb begin
        slot_free = !vld_q || m_tready;
        busy      = vld_q;
        m_tdata   = dat_q;
        m_tuser   = mrk_q.sof;
        m_tlast   = mrk_q.eol;
    end

endmodule

// File: rtl/video_frame_streamer.sv
module video_frame_streamer
    import vfs_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int ACT_W    = 1920,
    parameter int ACT_H    = 1080,
    parameter int HGAP_W   = 12,
    parameter int VGAP_W   = 8,
    parameter int HGAP_DEF = 280,
    parameter int VGAP_DEF = 45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HGAP_W-1:0] cfg_hgap,
    input  logic [VGAP_W-1:0] cfg_vgap,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_valid,
    output logic              src_ready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tuser,
    output logic              m_tlast
);

    logic              fetch_ok, slot_free, busy, take, frame_done;
    pix_mark_t         fetch_mark;
    logic [HGAP_W-1:0] hgap;
    logic [VGAP_W-1:0] vgap;

    always_comb begin
        src_ready = fetch_ok && slot_free;
        take      = src_ready && src_valid;
        m_tvalid  = busy;
    end

    vfs_gap_regs #(
        .HGAP_W  (HGAP_W),
        .VGAP_W  (VGAP_W),
        .HGAP_DEF(HGAP_DEF),
        .VGAP_DEF(VGAP_DEF)
    ) u_gaps (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_done(frame_done),
        .cfg_hgap  (cfg_hgap),
        .cfg_vgap  (cfg_vgap),
        .hgap      (hgap),
        .vgap      (vgap)
    );

    vfs_raster_fsm #(
        .ACT_W (ACT_W),
        .ACT_H (ACT_H),
        .HGAP_W(HGAP_W),
        .VGAP_W(VGAP_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_busy  (busy),
        .take      (take),
        .hgap      (hgap),
        .vgap      (vgap),
        .fetch_ok  (fetch_ok),
        .fetch_mark(fetch_mark),
        .frame_done(frame_done)
    );

    vfs_out_reg #(
        .DATA_W(DATA_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .in_data  (src_data),
        .in_mark  (fetch_mark),
        .m_tready (m_tready),
        .slot_free(slot_free),
        .busy     (busy),
        .m_tdata  (m_tdata),
        .m_tuser  (m_tuser),
        .m_tlast  (m_tlast)
    );

endmodule

// File: rtl/video_frame_streamer_chk.sv
module video_frame_streamer_chk #(
    parameter int DATA_W = 24,
    parameter int ACT_W  = 1920,
    parameter int ACT_H  = 1080
) (
    input logic              clk,
    input logic              rst_n,
    input logic              src_ready,
    input logic [DATA_W-1:0] m_tdata,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic              m_tuser,
    input logic              m_tlast
);

    localparam int BW = (ACT_W > 1) ? $clog2(ACT_W) : 1;
    localparam int LW = (ACT_H > 1) ? $clog2(ACT_H) : 1;

    logic [BW-1:0] beat_q;
    logic [LW-1:0] line_q;
    logic          fire;

    assign fire = m_tvalid && m_tready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
            line_q <= '0;
        end else if (fire) begin
            if (beat_q == BW'(ACT_W - 1)) begin
                beat_q <= '0;
                line_q <= (line_q == LW'(ACT_H - 1)) ? '0 : line_q + LW'(1);
            end else begin
                beat_q <= beat_q + BW'(1);
            end
        end
    end

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast))); // R7

    AST_NO_FETCH_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |-> !src_ready); // R7

    AST_LAST_AT_LINE_END: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (m_tlast == (beat_q == BW'(ACT_W - 1)))); // R3

    AST_USER_AT_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (m_tuser == ((beat_q == '0) && (line_q == '0)))); // R2

endmodule

bind video_frame_streamer video_frame_streamer_chk #(
    .DATA_W(DATA_W),
    .ACT_W (ACT_W),
    .ACT_H (ACT_H)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_ready(src_ready),
    .m_tdata  (m_tdata),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tuser  (m_tuser),
    .m_tlast  (m_tlast)
);

// File: tb/video_frame_streamer_tb.sv
`timescale 1ns/100ps
module video_frame_streamer_tb;

    localparam int W    = 8;
    localparam int H    = 3;
    localparam int DW   = 16;
    localparam int HGW  = 10;
    localparam int VGW  = 6;
    localparam int NFR  = 6;
    localparam int FULL = 4;
    localparam int FPIX = W * H;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [HGW-1:0] cfg_hgap = HGW'(3);
    logic [VGW-1:0] cfg_vgap = VGW'(2);
    logic [DW-1:0]  src_data;
    logic           src_valid = 1'b0;
    logic           src_ready;
    logic [DW-1:0]  m_tdata;
    logic           m_tvalid;
    logic           m_tready = 1'b1;
    logic           m_tuser;
    logic           m_tlast;

    always #2.5 clk = ~clk;

    video_frame_streamer #(
        .DATA_W(DW), .ACT_W(W), .ACT_H(H), .HGAP_W(HGW), .VGAP_W(VGW),
        .HGAP_DEF(280), .VGAP_DEF(45)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_hgap(cfg_hgap), .cfg_vgap(cfg_vgap),
        .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tuser(m_tuser), .m_tlast(m_tlast)
    );

    typedef struct packed {
        logic [DW-1:0] d;
        logic          u;
        logic          l;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   hp_of[NFR] = '{280, 3, 0, 4, 4, 4};
    int   vp_of[NFR] = '{45, 2, 0, 1, 1, 1};
    int   fire_cnt = 0;
    int   push_cnt = 0;
    bit   running = 0;
    bit   stall_mode = 0;
    bit   took = 0;
    bit   finished = 0;
    logic [DW-1:0] nxt_pix = 16'h0100;

    assign src_data = nxt_pix;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // driver: pushes the expected item for each accepted pixel
    task automatic drive_cycle();
        if (took) begin
            exp_t e;
            e.d = nxt_pix;
            e.u = (push_cnt % FPIX) == 0;
            e.l = (push_cnt % W) == W - 1;
            q.push_back(e);
            push_cnt++;
            nxt_pix = nxt_pix + DW'(7);
        end
        if (stall_mode) begin
            src_valid = ($urandom % 4) != 0;
            m_tready  = ($urandom % 3) != 0;
        end else begin
            src_valid = 1'b1;
            m_tready  = 1'b1;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (running) drive_cycle();
        end
    end

    // monitor / scoreboard
    int   idle = 0;
    int   takes_gap = 0;
    bit   prev_last = 0;
    bit   prev_stall = 0;
    logic [DW-1:0] pv_d;
    logic pv_u, pv_l;

    always @(negedge clk) begin
        if (rst_n && running && !finished) begin
            automatic bit fire = m_tvalid && m_tready;
            automatic bit take = src_valid && src_ready;
            took = take;
            if (prev_stall) begin
                chk(m_tvalid == 1'b1, "R7", "tvalid held", m_tvalid, 1);
                chk(m_tdata == pv_d, "R7", "tdata held", m_tdata, pv_d);
                chk({m_tuser, m_tlast} == {pv_u, pv_l}, "R7", "markers held",
                    {m_tuser, m_tlast}, {pv_u, pv_l});
            end
            if (m_tvalid && !m_tready)
                chk(src_ready == 1'b0, "R7", "src_ready during stall", src_ready, 0);
            if (fire) begin
                if (q.size() == 0) begin
                    chk(0, "R1", "transfer with empty scoreboard", 1, 0);
                end else begin
                    automatic exp_t e = q.pop_front();
                    chk(m_tdata == e.d, "R1", "pixel data", m_tdata, e.d);
                    chk(m_tuser == e.u, "R2", "tuser", m_tuser, e.u);
                    chk(m_tlast == e.l, "R3", "tlast", m_tlast, e.l);
                end
                if (fire_cnt > 0 && prev_last) begin
                    automatic int pf = (fire_cnt - 1) / FPIX;
                    automatic int pl = ((fire_cnt - 1) / W) % H;
                    if (pf < FULL) begin
                        automatic int hp = hp_of[pf];
                        automatic int vp = vp_of[pf];
                        automatic int ex = (pl < H - 1) ? hp : hp + vp * (W + hp);
                        automatic string tg = (pf == 0) ? "R10" :
                                              (pf == 1) ? "R6" :
                                              (hp == 0 && vp == 0) ? "R9" :
                                              (pl < H - 1) ? "R4" : "R5";
                        chk(idle == ex, tg, "blank length", idle, ex);
                        chk(takes_gap == ((ex > 0) ? 1 : 0), "R8", "source takes in blank",
                            takes_gap, (ex > 0) ? 1 : 0);
                    end
                end
                prev_last = m_tlast;
                fire_cnt++;
                idle = 0;
                takes_gap = 0;
            end else begin
                idle++;
                if (take) takes_gap++;
            end
            prev_stall = m_tvalid && !m_tready;
            pv_d = m_tdata;
            pv_u = m_tuser;
            pv_l = m_tlast;
        end
    end

    // control sequence
    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R10", "tvalid in reset", m_tvalid, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R10", "tvalid after reset", m_tvalid, 0);
        chk(src_ready == 1'b1, "R10", "src_ready after reset", src_ready, 1);
        @(posedge clk);
        #1;
        running = 1;
        drive_cycle();
        // mid-frame write during frame 1: must only affect frame 2
        while (fire_cnt < FPIX + W + 1) @(negedge clk);
        cfg_hgap = HGW'(0);
        cfg_vgap = VGW'(0);
        while (fire_cnt < 2 * FPIX + W + 1) @(negedge clk);
        cfg_hgap = HGW'(4);
        cfg_vgap = VGW'(1);
        while (fire_cnt < FULL * FPIX + 1) @(negedge clk);
        stall_mode = 1;
        while (fire_cnt < NFR * FPIX) @(negedge clk);
        stall_mode = 0;
        repeat (3) @(negedge clk);
        chk(q.size() <= 1, "R1", "scoreboard drained", q.size(), 0);
        finish_run();
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d transfers expected %0d", fire_cnt, NFR * FPIX);
            finish_run();
        end
    end

endmodule